// File: doc/BRIEF.md
# DC-Balanced Three-Lane Frame Encoder

This block is the transmit side of a three-lane serial link that is coupled through capacitors. Each lane receives a 7-bit word once per frame and sends it as 9 serial bits, one bit per clock. The block keeps a running sum for each lane, adding one for every transmitted one and subtracting one for every transmitted zero. At each frame boundary it uses the sign of that sum to choose between the word as given and its bitwise complement. The chosen form always pulls the sum back toward zero. The block then inserts a pair of complementary marker bits so that the receiver can undo the inversion.

A fourth serial output carries a frame-rate clock pattern. Its high time alternates between 4 and 5 bit periods from one frame to the next, so that this lane is also balanced over every pair of frames. A pulse on `take_o` tells the data source when the next 21-bit word is captured.

Top module: `dcb_frame_encoder`

## Requirements
- R1: `take_o` is high while reset is held. After reset it is high in the first cycle and then in every 9th cycle. `data_i` is captured at each rising edge where `take_o` is high.
- R2: For each lane k, the word is `data_i[7k+6:7k]` with bit 0 as d0. Starting in the cycle after the capture edge, the lane sends one bit per clock in the order d0, d1, d2, d3, d4, A, d5, d6, B. Each data bit is complemented when A is 1.
- R3: The second marker B is always the complement of the first marker A. A = 1 means the frame carries the complemented word.
- R4: Let n be the count of ones in the 7-bit word. If the lane's running sum is greater than zero, the word is complemented exactly when n > 3. Otherwise it is complemented exactly when n < 4.
- R5: The running sum starts at zero on reset and advances by the disparity of all 9 bits as sent, markers included. The sum is kept separately for each lane.
- R6: On each data lane, the running sum counted bit by bit from the first frame after reset never leaves the range -10 to +10.
- R7: The first clock-lane frame after reset is high for 4 bit periods and then low for 5. Frames then alternate with a pattern that is high for 5 and low for 4. The high part always comes first.
- R8: The bit-by-bit running sum of the clock lane never leaves the range -5 to +5.
- R9: While reset is held, all data lanes and the clock lane are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| data_i | input | 21 | Three 7-bit words, lane k in bits 7k+6..7k |
| take_o | output | 1 | High in the cycle whose rising edge captures data_i |
| lane_o | output | 3 | Serial data lanes, bit k is lane k |
| clk_lane_o | output | 1 | Serial frame-rate clock pattern |

## Verification
The bench uses the default parameters: three lanes, 7-bit words and the first marker in slot 5. With these values, one all-ones word lifts a lane's sum to its highest boundary value of +7. A 3-ones word that leads with its ones then carries the intra-frame peak to exactly +10. The three lanes also receive different words in the same frame, which shows that each lane decides from its own sum. The clock lane runs across hundreds of frames, so its 4/5 alternation and its sum bound are checked far past the first pair of frames.

// File: rtl/fenc_pkg.sv
package fenc_pkg;
    typedef enum logic {
        PH_SHORT_HI = 1'b0,
        PH_LONG_HI  = 1'b1
    } clk_phase_e;
endpackage

// File: rtl/fenc_lane.sv
module fenc_lane #(
    parameter int WBITS    = 7,
    parameter int MARK_POS = 5,
    parameter int SUM_W    = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WBITS-1:0] word_i,
    output logic             ser_o
);
    localparam int FBITS = WBITS + 2;

    typedef struct packed {
        logic [FBITS-1:0]        sh;
        logic signed [SUM_W-1:0] sum;
    } lane_st_t;

    lane_st_t st_q, st_d;
    logic             inv_d;
    logic [WBITS-1:0] sent_d;
    logic [FBITS-1:0] frame_d;
    int               ones_d;
    int               disp_d;

    always_comb begin
        ones_d = 0;
        for (int i = 0; i < WBITS; i++) ones_d = ones_d + int'(word_i[i]);
        disp_d = 2 * ones_d - WBITS;
        // pick the form that moves the sum toward zero
        if (st_q.sum > 0) inv_d = (disp_d > 0);
        else              inv_d = (disp_d < 0);
        sent_d = inv_d ? ~word_i : word_i;
        for (int i = 0; i < FBITS; i++) begin
            if (i == MARK_POS)       frame_d[i] = inv_d;
            else if (i == FBITS - 1) frame_d[i] = ~inv_d;
            else if (i < MARK_POS)   frame_d[i] = sent_d[i];
            else                     frame_d[i] = sent_d[i-1];
        end
        st_d = st_q;
        if (load_i) begin
            st_d.sh  = frame_d;
            st_d.sum = st_q.sum + $signed(SUM_W'(inv_d ? -disp_d : disp_d));
        end else begin
            st_d.sh  = st_q.sh >> 1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ser_o = st_q.sh[0];
endmodule

// File: rtl/fenc_clkgen.sv
module fenc_clkgen #(
    parameter int FBITS = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic ser_o
);
    import fenc_pkg::*;
    localparam int HI_SHORT = FBITS / 2;
    localparam int HI_LONG  = FBITS - FBITS / 2;

    typedef struct packed {
        logic [FBITS-1:0] sh;
        clk_phase_e       ph;
    } clk_st_t;

    clk_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            for (int i = 0; i < FBITS; i++)
                st_d.sh[i] = (st_q.ph == PH_SHORT_HI) ? (i < HI_SHORT) : (i < HI_LONG);
            st_d.ph = (st_q.ph == PH_SHORT_HI) ? PH_LONG_HI : PH_SHORT_HI;
        end else begin
            st_d.sh = st_q.sh >> 1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sh <= '0;
            st_q.ph <= PH_SHORT_HI;
        end else begin
            st_q <= st_d;
        end
    end

    assign ser_o = st_q.sh[0];
endmodule

// File: rtl/dcb_frame_encoder.sv
module dcb_frame_encoder #(
    parameter int LANES    = 3,
    parameter int WBITS    = 7,
    parameter int MARK_POS = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LANES*WBITS-1:0] data_i,
    output logic                   take_o,
    output logic [LANES-1:0]       lane_o,
    output logic                   clk_lane_o
);
    localparam int FBITS = WBITS + 2;
    localparam int CNT_W = $clog2(FBITS);
    localparam int SUM_W = $clog2(FBITS) + 3;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FBITS - 1);

    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= LAST;
        else        cnt_q <= cnt_d;
    end

    assign take_o = (cnt_q == LAST);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        fenc_lane #(
            .WBITS    (WBITS),
            .MARK_POS (MARK_POS),
            .SUM_W    (SUM_W)
        ) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (take_o),
            .word_i (data_i[l*WBITS +: WBITS]),
            .ser_o  (lane_o[l])
        );
    end

    fenc_clkgen #(.FBITS(FBITS)) u_clk (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (take_o),
        .ser_o  (clk_lane_o)
    );
endmodule

// File: rtl/fenc_chk.sv
module fenc_chk #(
    parameter int LANES    = 3,
    parameter int WBITS    = 7,
    parameter int MARK_POS = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             take_o,
    input logic [LANES-1:0] lane_o,
    input logic             clk_lane_o
);
    localparam int FBITS = WBITS + 2;
    localparam int BW    = $clog2(FBITS);
    localparam logic [BW-1:0] LASTB = BW'(FBITS - 1);
    localparam logic [BW-1:0] MARKB = BW'(MARK_POS);

    logic                   live_q;
    logic [BW-1:0]          beat_q;
    logic [LANES-1:0]       mark_q;
    logic signed [7:0]      lsum_q [LANES];
    logic signed [7:0]      csum_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q <= 1'b0;
            beat_q <= '0;
            mark_q <= '0;
            csum_q <= '0;
            for (int l = 0; l < LANES; l++) lsum_q[l] <= '0;
        end else begin
            if (take_o) begin
                live_q <= 1'b1;
                beat_q <= '0;
            end else if (live_q) begin
                beat_q <= beat_q + 1'b1;
            end
            if (live_q) begin
                for (int l = 0; l < LANES; l++)
                    lsum_q[l] <= lsum_q[l] + (lane_o[l] ? 8'sd1 : -8'sd1);
                csum_q <= csum_q + (clk_lane_o ? 8'sd1 : -8'sd1);
                if (beat_q == MARKB) mark_q <= lane_o;
            end
        end
    end

    AST_TAKE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> (take_o == (beat_q == LASTB))); // R1
    AST_MARK_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && beat_q == LASTB) |-> (lane_o == ~mark_q)); // R3
    AST_CLK_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && beat_q == '0) |-> clk_lane_o); // R7
    AST_CLK_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && beat_q == LASTB) |-> !clk_lane_o); // R7
    AST_CLK_DSV: assert property (@(posedge clk) disable iff (!rst_n)
        (csum_q <= 8'sd5 && csum_q >= -8'sd5)); // R8

    for (genvar l = 0; l < LANES; l++) begin : g_dsv
        AST_DATA_DSV: assert property (@(posedge clk) disable iff (!rst_n)
            (lsum_q[l] <= 8'sd10 && lsum_q[l] >= -8'sd10)); // R6
    end
endmodule

bind dcb_frame_encoder fenc_chk #(
    .LANES    (LANES),
    .WBITS    (WBITS),
    .MARK_POS (MARK_POS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_o     (take_o),
    .lane_o     (lane_o),
    .clk_lane_o (clk_lane_o)
);

// File: tb/sim_dcb_frame_encoder.sv
module sim_dcb_frame_encoder;
    localparam int NL = 3;
    localparam int NFRAMES = 320;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [20:0]   data_i = '0;
    logic          take_o;
    logic [2:0]    lane_o;
    logic          clk_lane_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    int exp_q [NL][$];
    int clk_q [$];
    int rds [NL];
    int bsum [NL];
    int csum = 0;
    int cphase = 0;
    int since = 8;
    int frames = 0;
    int obs_word [NL];
    int obs_beat = 0;
    int obs_frame = -1;

    always #4 clk = ~clk;

    dcb_frame_encoder u0 (
        .clk(clk), .rst_n(rst_n), .data_i(data_i),
        .take_o(take_o), .lane_o(lane_o), .clk_lane_o(clk_lane_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [6:0] pick(input int f, input int l);
        if (f < 6) return 7'h7F;
        if (f < 12) return (l == 0) ? 7'h00 : (l == 1) ? 7'h7F : 7'h55;
        if (f < 24) return (f % 2 == 0) ? 7'h07 : 7'h78;
        if (f < 30) return (l == 2) ? 7'h01 : 7'h3E;
        return 7'($urandom);
    endfunction

    // reference: expected 9-bit frame pushed as a bit list
    task automatic model_frame(input int l, input logic [6:0] w);
        int n;
        bit flip;
        int d;
        n = $countones(w);
        d = 2 * n - 7;
        if (rds[l] > 0) flip = (n > 3);
        else            flip = (n < 4);
        exp_q[l].push_back(w[0] ^ flip);
        exp_q[l].push_back(w[1] ^ flip);
        exp_q[l].push_back(w[2] ^ flip);
        exp_q[l].push_back(w[3] ^ flip);
        exp_q[l].push_back(w[4] ^ flip);
        exp_q[l].push_back(int'(flip));
        exp_q[l].push_back(w[5] ^ flip);
        exp_q[l].push_back(w[6] ^ flip);
        exp_q[l].push_back(int'(!flip));
        rds[l] = rds[l] + (flip ? -d : d);
    endtask

    task automatic step();
        if (clk_q.size() > 0) begin
            int ce;
            ce = clk_q.pop_front();
            chk(clk_lane_o == ce[0], "R7 clock lane bit", clk_lane_o, ce);
            csum = csum + (clk_lane_o ? 1 : -1);
            chk(csum <= 5 && csum >= -5, "R8 clock lane sum", csum, 5);
            for (int l = 0; l < NL; l++) begin
                int e;
                e = exp_q[l].pop_front();
                chk(lane_o[l] == e[0], "R2 R4 R5 lane bit", lane_o[l], e);
                bsum[l] = bsum[l] + (lane_o[l] ? 1 : -1);
                chk(bsum[l] <= 10 && bsum[l] >= -10, "R6 lane running sum", bsum[l], 10);
                obs_word[l] = obs_word[l] | (int'(lane_o[l]) << obs_beat);
            end
            obs_beat++;
            if (obs_beat == 9) begin
                if (obs_frame == 0)
                    chk(obs_word[0] == 'h1DF, "R4 first all-ones frame sent true", obs_word[0], 'h1DF);
                if (obs_frame == 1)
                    chk(obs_word[0] == 'h020, "R4 second all-ones frame inverted", obs_word[0], 'h020);
                if (obs_frame >= 0)
                    chk(obs_word[1][5] != obs_word[1][8], "R3 marker pair", obs_word[1], 0);
                obs_beat = 0;
                obs_frame++;
                for (int l = 0; l < NL; l++) obs_word[l] = 0;
            end
        end
        chk(take_o == (since == 8), "R1 take spacing", take_o, int'(since == 8));
        if (take_o) begin
            since = 0;
            for (int l = 0; l < NL; l++) begin
                logic [6:0] w;
                w = pick(frames, l);
                data_i[l*7 +: 7] = w;
                model_frame(l, w);
            end
            for (int b = 0; b < 9; b++) clk_q.push_back((b < (cphase == 0 ? 4 : 5)) ? 1 : 0);
            cphase = 1 - cphase;
            frames++;
        end else begin
            since++;
        end
    endtask

    initial begin
        for (int l = 0; l < NL; l++) begin
            rds[l] = 0; bsum[l] = 0; obs_word[l] = 0;
        end
        repeat (3) @(negedge clk);
        chk(lane_o == 3'b000, "R9 lanes low in reset", lane_o, 0);
        chk(clk_lane_o == 1'b0, "R9 clock lane low in reset", clk_lane_o, 0);
        chk(take_o == 1'b1, "R1 take high in reset", take_o, 1);
        rst_n = 1'b1;
        obs_frame = 0;
        step();
        while (frames < NFRAMES) begin
            @(negedge clk);
            step();
        end
        repeat (9) begin
            @(negedge clk);
            step();
        end
        for (int l = 0; l < NL; l++)
            chk(rds[l] <= 7 && rds[l] >= -6, "R5 boundary sum range", rds[l], 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL R1 watchdog expired actual=%0d expected=%0d", frames, NFRAMES);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule